// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block is the receive half of a synchronous serial port operating as a clock slave. A remote master drives a serial clock and a data line. The block brings both into the system clock domain, finds the selected clock edge, and shifts data in least significant bit first. It assembles characters of 8 or 9 bits.

Each finished character is written into a two-entry receive queue. The ninth bit is stored with its byte in the same entry. The host sees the byte at the head of the queue, that entry's ninth bit, a ready flag, an interrupt request gated by an enable, and a sticky overrun flag. A one-cycle read strobe removes the head entry.

Reception runs without interruption while the receiver is enabled. No per-character arming is needed. The control state machine has three states:
- `ST_OFF`: the receiver is disabled. The bit counter is held at zero.
- `ST_RECV`: the receiver is shifting bits in.
- `ST_OVR`: an overrun has occurred and characters are refused.

The transitions are:
- `ST_OFF` to `ST_RECV` when the port is in slave mode and reception is enabled.
- `ST_RECV` to `ST_OVR` when a character completes while the queue is full.
- `ST_RECV` to `ST_OFF`, and `ST_OVR` to `ST_OFF`, whenever slave mode or the receive enable drops.

Top module: `sync_slave_rx`

## Requirements
- R1: Characters are received only while `port_en`, `sync_mode` and `ext_clk_sel` are all 1. With any of them at 0, clock edges on `ser_clk` produce no character.
- R2: Reception is continuous. Characters sent back to back are all delivered in order, and nothing needs to be re-armed between them.
- R3: With `clk_pol`=0, `ser_dat` is sampled on rising edges of `ser_clk`. Bits are taken LSB first. In 8-bit mode (`nine_bit`=0) the byte appears on `rx_data` and `rx_bit9` reads 0.
- R4: With `clk_pol`=1, `ser_dat` is sampled on falling edges of `ser_clk`.
- R5: With `nine_bit`=1, each character is 9 bits long. The first 8 bits received go to `rx_data`, and the ninth goes to `rx_bit9`. Each queue entry keeps its own ninth bit.
- R6: `rx_ready` is 1 while the queue holds at least one entry. A cycle with `rd_strobe`=1 removes the oldest entry. `rx_ready` falls after the last entry is removed.
- R7: `irq` is 1 exactly when `rx_ready` and `irq_en` are both 1.
- R8: The queue holds two characters. A third character that completes while the queue is full sets `overrun` and is discarded. While `overrun` is set, every later character is discarded.
- R9: `overrun` stays set until `rx_en` or `port_en` goes to 0. Dropping `rx_en` keeps the characters already in the queue.
- R10: Dropping `rx_en` partway through a character discards the bits received so far. The next character starts from bit 0.
- R11: With `port_en`=0 the whole receiver is reset: the queue is emptied and `overrun` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable; 0 resets the receiver |
| sync_mode | input | 1 | Selects synchronous operation |
| ext_clk_sel | input | 1 | 1 selects an externally driven serial clock (slave) |
| rx_en | input | 1 | Continuous receive enable |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| clk_pol | input | 1 | 0 samples on rising edges, 1 on falling edges |
| irq_en | input | 1 | Receive interrupt enable |
| ser_clk | input | 1 | Serial clock from the master |
| ser_dat | input | 1 | Serial data from the master |
| rd_strobe | input | 1 | Removes the head entry of the queue |
| rx_data | output | 8 | Byte of the head entry |
| rx_bit9 | output | 1 | Ninth bit of the head entry |
| rx_ready | output | 1 | Queue holds at least one entry |
| irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a queue depth of 2. With that depth, three characters sent without a read are enough to reach the full-queue overrun, the discarding of later characters, and both ways of clearing the flag. The two-stage synchroniser keeps the delay from a serial edge to a queued character at a few system cycles. That allows a bit period of eight system clocks, so 8-bit, 9-bit, both clock polarities and a partial character can all be run in one short test.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int SRX_DW = 8;

    typedef struct packed {
        logic              b9;
        logic [SRX_DW-1:0] data;
    } srx_entry_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RECV = 2'd1,
        ST_OVR  = 2'd2
    } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic clk_pol,
    output logic smp_stb,
    output logic smp_bit
);
    logic [STAGES-1:0] ck_pipe;
    logic [STAGES-1:0] dt_pipe;
    logic              ck_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ck_pipe <= '0;
                    dt_pipe <= '0;
                end else begin
                    ck_pipe <= ser_clk;
                    dt_pipe <= ser_dat;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ck_pipe <= '0;
                    dt_pipe <= '0;
                end else begin
                    ck_pipe <= {ck_pipe[STAGES-2:0], ser_clk};
                    dt_pipe <= {dt_pipe[STAGES-2:0], ser_dat};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_prev <= 1'b0;
        else        ck_prev <= ck_pipe[STAGES-1];
    end

    always_comb begin
        if (clk_pol) smp_stb = ~ck_pipe[STAGES-1] & ck_prev;
        else         smp_stb = ck_pipe[STAGES-1] & ~ck_prev;
        smp_bit = dt_pipe[STAGES-1];
    end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       stb,
    input  logic       din,
    input  logic       full,
    output logic       push,
    output srx_entry_t entry,
    output logic       ovr
);
    localparam int CW = $clog2(SRX_DW + 1);

    srx_state_e       state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [SRX_DW-1:0] sh_q;
    logic [SRX_DW:0]  sh_next;
    logic             enabled, last;

    assign enabled = active & rx_en;
    assign sh_next = {din, sh_q};
    assign last    = (cnt_q == (nine_bit ? CW'(SRX_DW) : CW'(SRX_DW - 1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enabled) state_d = ST_RECV;
            ST_RECV: begin
                if (!enabled)                  state_d = ST_OFF;
                else if (stb && last && full)  state_d = ST_OVR;
            end
            ST_OVR:  if (!enabled) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // datapath: shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (state_q != ST_RECV || !enabled) begin
            cnt_q <= '0;
        end else if (stb) begin
            sh_q  <= sh_next[SRX_DW:1];
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        push = (state_q == ST_RECV) && enabled && stb && last && !full;
        ovr  = (state_q == ST_OVR);
        if (nine_bit) begin
            entry.b9   = sh_next[SRX_DW];
            entry.data = sh_next[SRX_DW-1:0];
        end else begin
            entry.b9   = 1'b0;
            entry.data = sh_next[SRX_DW:1];
        end
    end

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && enabled) |=> ovr);
    p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full));
    p_partial_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (cnt_q == '0));
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SRX_DW));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  srx_entry_t wdata,
    input  logic       pop,
    output srx_entry_t head,
    output logic       empty,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    srx_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [NW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == NW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= inc(wr_ptr);
            if (do_pop)  rd_ptr <= inc(rd_ptr);
            count <= count + NW'(do_push) - NW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= NW'(DEPTH));
    p_last_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == NW'(1) && pop && !push && !flush) |=> empty);
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              ext_clk_sel,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              clk_pol,
    input  logic              irq_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              rd_strobe,
    output logic [SRX_DW-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ready,
    output logic              irq,
    output logic              overrun
);
    logic       slave_active, stb, sbit, push, empty, full;
    srx_entry_t entry, head;

    assign slave_active = port_en & sync_mode & ext_clk_sel;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .clk_pol(clk_pol), .smp_stb(stb), .smp_bit(sbit)
    );

    srx_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .active(slave_active), .rx_en(rx_en),
        .nine_bit(nine_bit), .stb(stb), .din(sbit), .full(full),
        .push(push), .entry(entry), .ovr(overrun)
    );

    srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!port_en), .push(push),
        .wdata(entry), .pop(rd_strobe), .head(head), .empty(empty), .full(full)
    );

    assign rx_data  = head.data;
    assign rx_bit9  = head.b9;
    assign rx_ready = !empty;
    assign irq      = rx_ready & irq_en;

    p_port_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!rx_ready && !overrun));
    p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe && port_en) |=> rx_ready);
endmodule

// File: tb/sim_sync_slave_rx.sv
`timescale 1ns/1ps
module sim_sync_slave_rx;
    logic clk = 0, rst_n = 0;
    logic port_en = 0, sync_mode = 0, ext_clk_sel = 0, rx_en = 0;
    logic nine_bit = 0, clk_pol = 0, irq_en = 0;
    logic ser_clk = 0, ser_dat = 0;
    logic mon_rd = 0, man_rd = 0, mon_on = 0;
    logic rd_strobe;
    logic [7:0] rx_data;
    logic rx_bit9, rx_ready, irq, overrun;
    int total = 0, bad = 0;
    logic [8:0] exp_q[$];

    assign rd_strobe = mon_rd | man_rd;
    always #4 clk = ~clk;

    sync_slave_rx u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .ext_clk_sel(ext_clk_sel), .rx_en(rx_en), .nine_bit(nine_bit),
        .clk_pol(clk_pol), .irq_en(irq_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_ready(rx_ready), .irq(irq), .overrun(overrun)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = v[i];
            repeat (4) @(negedge clk);
            ser_clk = ~clk_pol;
            repeat (4) @(negedge clk);
            ser_clk = clk_pol;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic sendq(input logic [8:0] v);
        exp_q.push_back(nine_bit ? v : {1'b0, v[7:0]});
        send(v, nine_bit ? 9 : 8);
    endtask

    task automatic rd_chk(input logic [8:0] e, input string req);
        @(negedge clk);
        chk(rx_ready && {rx_bit9, rx_data} == e, req, {rx_ready, rx_bit9, rx_data}, {1'b1, e});
        man_rd = 1;
        @(negedge clk);
        man_rd = 0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && rx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected char", {rx_bit9, rx_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({rx_bit9, rx_data} == e, "R3/R4/R5 data", {rx_bit9, rx_data}, e);
                    chk(irq == irq_en, "R7 irq", irq, irq_en);
                end
                mon_rd = 1;
                @(negedge clk);
                mon_rd = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!rx_ready && !irq && !overrun, "reset", {rx_ready, irq, overrun}, 0);

        // R1: not slave mode
        port_en = 1; sync_mode = 1; ext_clk_sel = 0; rx_en = 1;
        repeat (4) @(negedge clk);
        send(9'h0F0, 8);
        chk(!rx_ready, "R1 ext clock off", rx_ready, 0);
        sync_mode = 0; ext_clk_sel = 1;
        repeat (4) @(negedge clk);
        send(9'h0F0, 8);
        chk(!rx_ready, "R1 sync off", rx_ready, 0);
        sync_mode = 1;
        repeat (4) @(negedge clk);

        // R2/R3: continuous 8-bit reception, rising edge
        mon_on = 1; irq_en = 1;
        sendq(9'h0A5); sendq(9'h03C); sendq(9'h001);
        irq_en = 0;
        sendq(9'h080);
        // R4: falling edge
        rx_en = 0; clk_pol = 1; ser_clk = 1;
        repeat (8) @(negedge clk);
        rx_en = 1;
        repeat (4) @(negedge clk);
        sendq(9'h081); sendq(9'h07E);
        // R5: nine-bit
        nine_bit = 1; irq_en = 1;
        sendq(9'h1AB); sendq(9'h055); sendq(9'h100);
        nine_bit = 0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all delivered", exp_q.size(), 0);
        mon_on = 0;

        // R8: overrun
        irq_en = 0;
        send(9'h011, 8); send(9'h022, 8); send(9'h033, 8);
        chk(overrun, "R8 overrun set", overrun, 1);
        chk(rx_ready && !irq, "R7 irq gated", irq, 0);
        irq_en = 1;
        @(negedge clk);
        chk(irq, "R7 irq enabled", irq, 1);
        rd_chk(9'h011, "R8 oldest kept");
        chk(rx_ready, "R6 ready after first read", rx_ready, 1);
        rd_chk(9'h022, "R8 second kept");
        chk(!rx_ready, "R6 ready drops", rx_ready, 0);
        send(9'h044, 8);
        chk(!rx_ready && overrun, "R8 ignored while overrun", {rx_ready, overrun}, 1);
        rx_en = 0;
        repeat (2) @(negedge clk);
        chk(!overrun, "R9 cleared by rx_en", overrun, 0);

        // R9: rx_en drop keeps FIFO
        rx_en = 1;
        repeat (4) @(negedge clk);
        send(9'h055, 8);
        rx_en = 0;
        repeat (4) @(negedge clk);
        rd_chk(9'h055, "R9 fifo kept");

        // R10: partial char dropped
        rx_en = 1;
        repeat (4) @(negedge clk);
        send(9'h00F, 4);
        rx_en = 0;
        repeat (4) @(negedge clk);
        rx_en = 1;
        repeat (4) @(negedge clk);
        send(9'h066, 8);
        rd_chk(9'h066, "R10 restart");
        chk(!rx_ready, "R10 single char", rx_ready, 0);

        // R11: port disable resets
        send(9'h077, 8); send(9'h088, 8); send(9'h099, 8);
        chk(overrun && rx_ready, "R11 precondition", {overrun, rx_ready}, 3);
        port_en = 0;
        repeat (3) @(negedge clk);
        chk(!rx_ready && !overrun, "R11 reset", {rx_ready, overrun}, 0);
        port_en = 1;
        repeat (4) @(negedge clk);
        send(9'h05A, 8);
        rd_chk(9'h05A, "R11 resumes");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule